// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

The unit performs two operations on 64-bit operands and keeps a 32-bit byte-selection mask between them. The mask-set operation adds its two operands. It returns the full sum as its result, and the low 32 bits of that sum become the new mask. The shuffle operation uses the stored mask to build a 64-bit result from a pool of 16 bytes, made up of the eight bytes of each operand. Each 4-bit mask nibble names the source byte for one output byte.

The mask is not an operand. A caller sets it once with a mask-set operation and then issues any number of shuffles. The mask is readable as the upper half of a 64-bit status word. The lower half is a general field that a separate write port loads. One operation is accepted every cycle, and each result is registered one cycle after its strobe.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While `rst_ni` is low, `res_o` is 0, `res_valid_o` is 0 and `stat_o` is 0.
- R2: A mask-set operation (`op_sel_i` = 0) sets `res_o` to `opa_i + opb_i` modulo 2^64 one cycle after the strobe. A carry out of bit 63 is dropped.
- R3: A mask-set operation writes bits 31:0 of the sum into `stat_o[63:32]` on the edge that registers its result. It leaves `stat_o[31:0]` unchanged.
- R4: A shuffle (`op_sel_i` = 1) sets byte i of `res_o` (bits 8i+7:8i) to the byte chosen by mask nibble `stat_o[32+4i+3:32+4i]`. A nibble value v from 0 to 7 chooses byte v of `opa_i`, counting from the least significant byte. A value from 8 to 15 chooses byte v-8 of `opb_i`.
- R5: After reset the mask is zero, so a shuffle with no earlier mask-set copies byte 0 of `opa_i` into all eight result bytes.
- R6: A shuffle strobed in the cycle right after a mask-set uses the mask written by that mask-set.
- R7: `res_valid_o` is 1 in the cycle after each strobe cycle and 0 after each cycle with no strobe. Strobes may arrive on consecutive cycles.
- R8: When `stat_wr_i` is 1, `stat_wdata_i` is loaded into `stat_o[31:0]` one cycle later. `stat_o[63:32]` is untouched, unless a mask-set in the same cycle writes it; in that case both fields take their new values.
- R9: A shuffle does not change any bit of `stat_o`.
- R10: In a cycle with no strobe, `res_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_sel_i | input | 1 | Operation select: 0 = mask-set, 1 = shuffle |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| stat_wr_i | input | 1 | Write enable for the low status field |
| stat_wdata_i | input | 32 | Data for the low status field |
| res_o | output | 64 | Registered result |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| stat_o | output | 64 | Status word: {mask, low field} |

## Verification
The bench builds the unit with its default 64-bit width. That width gives eight lanes and 4-bit selectors, so every one of the 16 pool positions can be reached from random masks. Directed sequences cover the zero mask left by reset and the 2^64 wrap of the sum. They also cover a shuffle issued right after a mask-set, and a low-field write in the same cycle as a mask-set. A long random mix of back-to-back operations, idle cycles and low-field writes is then compared against the reference model on every clock.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic {
    OP_MASK_SET = 1'b0,
    OP_SHUFFLE  = 1'b1
  } bsu_op_e;
endpackage

// File: rtl/bsu_adder.sv
module bsu_adder #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // carry out intentionally dropped
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/bsu_xbar.sv
module bsu_xbar #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SEL_W = $clog2(2 * LANES)
) (
  input  logic [LANES*8-1:0]     src_lo_i,
  input  logic [LANES*8-1:0]     src_hi_i,
  input  logic [LANES*SEL_W-1:0] mask_i,
  output logic [LANES*8-1:0]     out_o
);
  localparam int unsigned POOL = 2 * LANES;

  logic [POOL*8-1:0] pool;
  assign pool = {src_hi_i, src_lo_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = mask_i[g*SEL_W +: SEL_W];
    assign out_o[g*8 +: 8] = pool[sel*8 +: 8];
  end
endmodule

// File: rtl/bsu_status.sv
module bsu_status #(
  parameter int unsigned MASK_W = 32,
  parameter int unsigned LOW_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_d_i,
  input  logic              low_we_i,
  input  logic [LOW_W-1:0]  low_d_i,
  output logic [MASK_W-1:0] mask_q_o,
  output logic [LOW_W-1:0]  low_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
      low_q_o  <= '0;
    end else begin
      if (mask_we_i) mask_q_o <= mask_d_i;
      if (low_we_i)  low_q_o  <= low_d_i;
    end
  end

  AST_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_we_i |=> $stable(low_q_o)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q_o)); // R9
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_sel_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W/2-1:0] stat_wdata_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] stat_o
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned SEL_W  = $clog2(2 * LANES);
  localparam int unsigned MASK_W = LANES * SEL_W;
  localparam int unsigned LOW_W  = DATA_W - MASK_W;

  bsu_op_e op;
  logic    do_set, do_shuf;
  assign op      = bsu_op_e'(op_sel_i);
  assign do_set  = op_valid_i && (op == OP_MASK_SET);
  assign do_shuf = op_valid_i && (op == OP_SHUFFLE);

  logic [DATA_W-1:0] sum, shuf;
  logic [MASK_W-1:0] mask_q;
  logic [LOW_W-1:0]  low_q;

  bsu_adder #(.W(DATA_W)) u_adder (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .sum_o(sum)
  );

  bsu_xbar #(.LANES(LANES), .SEL_W(SEL_W)) u_xbar (
    .src_lo_i(opa_i),
    .src_hi_i(opb_i),
    .mask_i  (mask_q),
    .out_o   (shuf)
  );

  bsu_status #(.MASK_W(MASK_W), .LOW_W(LOW_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(do_set),
    .mask_d_i (sum[MASK_W-1:0]),
    .low_we_i (stat_wr_i),
    .low_d_i  (stat_wdata_i[LOW_W-1:0]),
    .mask_q_o (mask_q),
    .low_q_o  (low_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= op_valid_i;
      if (do_set)       res_o <= sum;
      else if (do_shuf) res_o <= shuf;
    end
  end

  assign stat_o = {mask_q, low_q};

  AST_VALID_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> res_valid_o); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !res_valid_o); // R7
  AST_SUM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_set |=> res_o == $past(opa_i + opb_i)); // R2
  AST_MASK_FROM_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_set |=> stat_o[DATA_W-1:LOW_W] == res_o[MASK_W-1:0]); // R3
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(res_o)); // R10
  AST_SHUF_STAT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shuf && !stat_wr_i) |=> $stable(stat_o)); // R9
endmodule

// File: tb/byte_shuffle_unit_bench.sv
module byte_shuffle_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [63:0] res;
  logic        res_valid;
  logic [63:0] stat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  byte_shuffle_unit u_byte_shuffle_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_sel_i(op_sel),
    .opa_i(opa), .opb_i(opb), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .res_o(res), .res_valid_o(res_valid), .stat_o(stat)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_shuffle(logic [31:0] m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int v = int'((m >> (4 * i)) & 32'hf);
      logic [7:0] byt;
      if (v < 8) byt = 8'((a >> (8 * v)) & 64'hff);
      else       byt = 8'((b >> (8 * (v - 8))) & 64'hff);
      r = r | (64'(byt) << (8 * i));
    end
    return r;
  endfunction

  // reference model
  logic [31:0] m_mask = '0, m_low = '0;
  logic [63:0] m_res = '0;
  logic        m_valid = 1'b0;
  string       m_tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_low = '0; m_res = '0; m_valid = 1'b0; m_tag = "R1";
    end else begin
      logic [63:0] s;
      s = opa + opb;
      m_valid = op_valid;
      if (op_valid && !op_sel) begin
        m_res = s; m_tag = "R2";
      end else if (op_valid && op_sel) begin
        m_res = ref_shuffle(m_mask, opa, opb); m_tag = "R4";
      end else m_tag = "R10";
      if (op_valid && !op_sel) m_mask = s[31:0];
      if (stat_wr) m_low = stat_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(m_tag, res, m_res);
      check("R7", 64'(res_valid), 64'(m_valid));
      check("R3", 64'(stat[63:32]), 64'(m_mask));
      check("R8", 64'(stat[31:0]), 64'(m_low));
    end
  end

  task automatic op(bit sel, logic [63:0] a, logic [63:0] b);
    op_valid = 1'b1; op_sel = sel; opa = a; opb = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", res, 64'h0);
    check("R1", 64'(res_valid), 64'h0);
    check("R1", stat, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: zero mask after reset
    op(1'b1, 64'h1122334455667788, 64'hffeeddccbbaa9988);
    check("R5", res, 64'h8888888888888888);

    // R2 wrap, R6 shuffle right after mask-set (reverse of opb)
    op_valid = 1'b1; op_sel = 1'b0;
    opa = 64'hffffffff80000000; opb = 64'h0000000109abcdef;
    @(negedge clk);
    check("R2", res, 64'h0000000089abcdef);
    check("R3", stat, 64'h89abcdef00000000);
    op_sel = 1'b1; opa = 64'h1111111111111111; opb = 64'h0102030405060708;
    @(negedge clk);
    op_valid = 1'b0;
    check("R6", res, 64'h0807060504030201);
    check("R9", stat, 64'h89abcdef00000000);

    // R8: low write alone, then together with a mask-set
    stat_wr = 1'b1; stat_wdata = 32'hcafe0001;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R8", stat, 64'h89abcdefcafe0001);
    check("R10", res, 64'h0807060504030201);
    stat_wr = 1'b1; stat_wdata = 32'h0000beef;
    op(1'b0, 64'h0000000076543210, 64'h0);
    stat_wr = 1'b0;
    check("R8", stat, 64'h765432100000beef);
    op(1'b1, 64'h0123456789abcdef, 64'h0);
    check("R4", res, 64'h0123456789abcdef);

    // random back-to-back mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      op_valid = (k < 8);
      op_sel   = (k >= 3);
      opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
      stat_wr = ($urandom_range(0, 3) == 0);
      stat_wdata = $urandom;
      @(negedge clk);
    end
    op_valid = 1'b0; stat_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule